// File: doc/BRIEF.md
# Dual-Entry Colour Palette Lookup

This block is the colour table of a display pipeline. Software sees it as 128 words of 32 bits in a window of the register space. Every word holds two 16-bit colour entries, so the table has 256 logical entries. Each entry keeps a 5-bit red, green and blue field and one intensity bit, which the block ignores.

The pixel side gives an 8-bit palette index every cycle. One cycle later the block returns a 24-bit colour. Each channel is widened from 5 to 8 bits by a left shift of three. A swap input, taken together with the index, exchanges the red and blue bytes of the result. This serves panels wired for blue-green-red order.

The bus side writes words and reads them back unchanged. An access outside the window does not touch the table.

Top module: `pal_lut`

## Requirements
- R1: A bus write with `bus_addr` in 0x200..0x3FF stores `bus_wdata` in word (`bus_addr` − 0x200) >> 2. A bus read of that address returns the exact 32-bit word on `bus_rdata` in the cycle after `bus_rd` is sampled. `bus_rdata` holds its value while `bus_rd` is low.
- R2: A write outside 0x200..0x3FF changes no word. A read outside it returns zero.
- R3: `pix_idx` bit 0 selects the half of a word: 0 selects bits [15:0] and 1 selects bits [31:16]. `pix_idx` bits [7:1] select the word.
- R4: In a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. With no swap, `pix_rgb` is red in [23:16], green in [15:8] and blue in [7:0].
- R5: Each output channel is the 5-bit field shifted left by three. The low three bits of every output byte are zero.
- R6: Entry bit 15 has no effect on `pix_rgb`.
- R7: When `pix_bgr` is 1 in the cycle the index is sampled, blue goes to [23:16] and red goes to [7:0]. Green stays in [15:8].
- R8: `pix_rgb` reflects the index given one cycle earlier. A bus write and a lookup of the same word in the same cycle return the data held before the write.
- R9: After reset, `pix_rgb` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_idx | input | 8 | Palette index from the pixel side |
| pix_bgr | input | 1 | Swap red and blue in the result |
| pix_rgb | output | 24 | Registered 8:8:8 colour |

## Verification
The assertions check several properties on every cycle:
- the zero low bits of each output byte;
- the zero result of an out-of-window read;
- the cleared outputs after reset;
- the rule that the colour stays constant while the index, the swap and the table stay unchanged.

Only the bench's scenarios can show the field positions, the half selection, the red/blue exchange and the bit-15 independence. The same holds for old data on a same-cycle write and lookup, and for the absence of aliasing just below and just above the window.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int ENTRY_W  = 16;
    localparam int CH_IN_W  = 5;
    localparam int CH_OUT_W = 8;
    localparam int SHIFT    = CH_OUT_W - CH_IN_W;
    localparam int NUM_CH   = 3;
    localparam int RGB_W    = NUM_CH * CH_OUT_W;

    // 16-bit stored colour entry, bit 15 first
    typedef struct packed {
        logic                 intens;
        logic [CH_IN_W-1:0]   blu;
        logic [CH_IN_W-1:0]   grn;
        logic [CH_IN_W-1:0]   red;
    } pal_entry_t;

    // 24-bit output colour, first field in the top byte
    typedef struct packed {
        logic [CH_OUT_W-1:0]  hi;
        logic [CH_OUT_W-1:0]  mid;
        logic [CH_OUT_W-1:0]  lo;
    } pix_rgb_t;

    typedef enum logic {
        ORDER_RGB = 1'b0,
        ORDER_BGR = 1'b1
    } ch_order_e;

    function automatic logic [CH_OUT_W-1:0] widen(input logic [CH_IN_W-1:0] c);
        return {c, {SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 32'h200,
    parameter int WORDS  = 128,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int SPAN = WORDS * 4;
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SPAN);

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] off;

    always_comb begin
        addr_x = {1'b0, addr};
        off    = addr_x - LO;
        hit    = (addr_x >= LO) && (addr_x < HI);
        idx    = IDX_W'(off >> 2);
    end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    parameter int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              bus_rd_en,
    input  logic              bus_rd_hit,
    input  logic [IDX_W-1:0]  bus_rd_idx,
    output logic [WORD_W-1:0] bus_rd_q,
    input  logic [IDX_W-1:0]  pix_rd_idx,
    output logic [WORD_W-1:0] pix_rd_q
);
    logic [WORD_W-1:0] mem [WORDS];

    // table storage, no reset: contents are software-defined
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // bus read port: registered, zero outside the window
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rd_q <= '0;
        end else if (bus_rd_en) begin
            bus_rd_q <= bus_rd_hit ? mem[bus_rd_idx] : '0;
        end
    end

    // pixel read port: registered every cycle, read-before-write
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_rd_q <= '0;
        end else begin
            pix_rd_q <= mem[pix_rd_idx];
        end
    end
endmodule

// File: rtl/pal_format.sv
module pal_format
    import pal_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int HALVES = WORD_W / ENTRY_W
) (
    input  logic [WORD_W-1:0]         word,
    input  logic [$clog2(HALVES)-1:0] half,
    input  ch_order_e                 order,
    output logic [RGB_W-1:0]          rgb
);
    pal_entry_t entries [HALVES];
    pal_entry_t sel;
    pix_rgb_t   out_s;

    genvar h;
    generate
        for (h = 0; h < HALVES; h++) begin : g_half
            assign entries[h] = pal_entry_t'(word[h*ENTRY_W +: ENTRY_W]);
        end
    endgenerate

    always_comb begin
        sel = entries[half];
        // intensity bit deliberately unused in the conversion
        out_s.mid = widen(sel.grn);
        if (order == ORDER_BGR) begin
            out_s.hi = widen(sel.blu);
            out_s.lo = widen(sel.red);
        end else begin
            out_s.hi = widen(sel.red);
            out_s.lo = widen(sel.blu);
        end
        rgb = out_s;
    end
endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BASE   = 32'h200,
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int HALVES = WORD_W / ENTRY_W,
    localparam int HSEL_W = $clog2(HALVES),
    localparam int PIX_W  = IDX_W + HSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [PIX_W-1:0]  pix_idx,
    input  logic              pix_bgr,
    output logic [RGB_W-1:0]  pix_rgb
);
    logic              acc_hit;
    logic [IDX_W-1:0]  acc_idx;
    logic [WORD_W-1:0] pix_word_q;
    logic [HSEL_W-1:0] half_q;
    ch_order_e         order_q;

    pal_bus_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .WORDS  (WORDS),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr (bus_addr),
        .hit  (acc_hit),
        .idx  (acc_idx)
    );

    pal_store #(
        .WORDS  (WORDS),
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_wr && acc_hit),
        .wr_idx     (acc_idx),
        .wr_data    (bus_wdata),
        .bus_rd_en  (bus_rd),
        .bus_rd_hit (acc_hit),
        .bus_rd_idx (acc_idx),
        .bus_rd_q   (bus_rdata),
        .pix_rd_idx (pix_idx[PIX_W-1:HSEL_W]),
        .pix_rd_q   (pix_word_q)
    );

    // half select and channel order travel alongside the word read
    always_ff @(posedge clk) begin
        if (rst) begin
            half_q  <= '0;
            order_q <= ORDER_RGB;
        end else begin
            half_q  <= pix_idx[HSEL_W-1:0];
            order_q <= pix_bgr ? ORDER_BGR : ORDER_RGB;
        end
    end

    pal_format #(
        .WORD_W (WORD_W)
    ) u_fmt (
        .word  (pix_word_q),
        .half  (half_q),
        .order (order_q),
        .rgb   (pix_rgb)
    );
endmodule

// File: rtl/pal_lut_chk.sv
module pal_lut_chk #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 32'h200,
    parameter int WORDS  = 128,
    parameter int WORD_W = 32,
    parameter int PIX_W  = 8,
    parameter int RGB_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [PIX_W-1:0]  pix_idx,
    input logic              pix_bgr,
    input logic [RGB_W-1:0]  pix_rgb
);
    logic outside;
    always_comb begin
        outside = (int'(bus_addr) < BASE) || (int'(bus_addr) >= BASE + WORDS * 4);
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pix_rgb == '0 && bus_rdata == '0));

    // R5
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_rgb[2:0] == 3'b0 && pix_rgb[10:8] == 3'b0 && pix_rgb[18:16] == 3'b0));

    // R2
    outside_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && outside) |=> (bus_rdata == '0));

    // R8
    steady_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr ##1 ($stable(pix_idx) && $stable(pix_bgr))) |=> $stable(pix_rgb));
endmodule

bind pal_lut pal_lut_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .WORDS  (WORDS),
    .WORD_W (WORD_W),
    .PIX_W  (PIX_W),
    .RGB_W  (pal_pkg::RGB_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pix_idx   (pix_idx),
    .pix_bgr   (pix_bgr),
    .pix_rgb   (pix_rgb)
);

// File: tb/pal_lut_bench.sv
module pal_lut_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx;
    logic        pix_bgr;
    logic [23:0] pix_rgb;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [31:0] model [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_lut u_pal_lut (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_bgr(pix_bgr), .pix_rgb(pix_rgb)
    );

    function automatic logic [23:0] exp_rgb(input logic [31:0] w, input bit hi, input bit bgr);
        logic [15:0] e;
        logic [7:0] r, g, b;
        e = hi ? w[31:16] : w[15:0];
        r = {e[4:0], 3'b000};
        g = {e[9:5], 3'b000};
        b = {e[14:10], 3'b000};
        return bgr ? {b, g, r} : {r, g, b};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 12'h200 && a < 12'h400) model[(a - 12'h200) >> 2] = d;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic lookup(input logic [7:0] i, input bit bgr, output logic [23:0] c);
        @(negedge clk);
        pix_idx = i; pix_bgr = bgr;
        @(negedge clk);
        c = pix_rgb;
    endtask

    task automatic t_reset;
        // R9
        check("R9 rgb", {8'h0, pix_rgb}, 32'h0);
        check("R9 rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        bus_write(12'h200, 32'hDEAD_BEEF);
        bus_write(12'h3FC, 32'h1234_5678);
        bus_write(12'h2A4, 32'hFFFF_0001);
        bus_read(12'h200, d); check("R1 word0", d, 32'hDEAD_BEEF);
        bus_read(12'h3FC, d); check("R1 word127", d, 32'h1234_5678);
        bus_read(12'h2A4, d); check("R1 word41", d, 32'hFFFF_0001);
        // R1 hold while bus_rd low
        repeat (2) @(negedge clk);
        check("R1 hold", bus_rdata, 32'hFFFF_0001);
    endtask

    task automatic t_fields;
        logic [23:0] c;
        // R4 pure channels in the low half of word 5
        bus_write(12'h214, {16'h7C00, 16'h001F});
        lookup(8'd10, 1'b0, c); check("R4 red", {8'h0, c}, {8'h0, 24'hF8_00_00});
        lookup(8'd11, 1'b0, c); check("R4 blue", {8'h0, c}, {8'h0, 24'h00_00_F8});
        bus_write(12'h218, {16'h0000, 16'h03E0});
        lookup(8'd12, 1'b0, c); check("R4 green", {8'h0, c}, {8'h0, 24'h00_F8_00});
        // R5 mixed fields
        bus_write(12'h220, {16'h2A55, 16'h5295});
        lookup(8'd16, 1'b0, c); check("R5 low half", {8'h0, c}, {8'h0, exp_rgb(model[8], 0, 0)});
        // R3 bit 0 picks upper half
        lookup(8'd17, 1'b0, c); check("R3 high half", {8'h0, c}, {8'h0, exp_rgb(model[8], 1, 0)});
        lookup(8'd255, 1'b0, c); check("R3 last entry", {8'h0, c}, {8'h0, exp_rgb(model[127], 1, 0)});
    endtask

    task automatic t_intensity;
        logic [23:0] a, b;
        bus_write(12'h230, {16'h8000 | 16'h1234, 16'h1234});
        lookup(8'd24, 1'b0, a);
        lookup(8'd25, 1'b0, b);
        // R6
        check("R6 intensity", {8'h0, b}, {8'h0, a});
        check("R6 value", {8'h0, a}, {8'h0, exp_rgb(32'h0000_1234, 0, 0)});
    endtask

    task automatic t_swap;
        logic [23:0] c;
        lookup(8'd10, 1'b1, c); check("R7 red to low", {8'h0, c}, {8'h0, 24'h00_00_F8});
        lookup(8'd17, 1'b1, c); check("R7 mixed", {8'h0, c}, {8'h0, exp_rgb(model[8], 1, 1)});
        lookup(8'd12, 1'b1, c); check("R7 green kept", {8'h0, c}, {8'h0, 24'h00_F8_00});
    endtask

    task automatic t_outside;
        logic [31:0] d;
        logic [23:0] c;
        bus_write(12'h400, 32'hAAAA_AAAA);
        bus_write(12'h1FC, 32'h5555_5555);
        bus_read(12'h200, d); check("R2 no alias above", d, model[0]);
        bus_read(12'h3FC, d); check("R2 no alias below", d, model[127]);
        lookup(8'd0, 1'b0, c); check("R2 lookup word0", {8'h0, c}, {8'h0, exp_rgb(model[0], 0, 0)});
        bus_read(12'h400, d); check("R2 read above", d, 32'h0);
        bus_read(12'h1FC, d); check("R2 read below", d, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] old_w;
        old_w = model[50];
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h200 + 12'd200; bus_wdata = 32'h7FFF_7C1F;
        pix_idx = 8'd100; pix_bgr = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
        model[50] = 32'h7FFF_7C1F;
        // R8 old data on same-cycle write and lookup
        check("R8 old data", {8'h0, pix_rgb}, {8'h0, exp_rgb(old_w, 0, 0)});
        @(negedge clk);
        check("R8 new data", {8'h0, pix_rgb}, {8'h0, exp_rgb(model[50], 0, 0)});
        // R8 one-cycle latency on an index change
        pix_idx = 8'd101;
        @(negedge clk);
        check("R8 latency", {8'h0, pix_rgb}, {8'h0, exp_rgb(model[50], 1, 0)});
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 32'h0;
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
        pix_idx = '0; pix_bgr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        for (int i = 0; i < 128; i++) bus_write(12'h200 + 12'(i * 4), 32'h0);
        t_readback();
        t_fields();
        t_intensity();
        t_swap();
        t_outside();
        t_collide();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule